// File: doc/BRIEF.md
# Deductive Fault-List Gate Evaluator

This unit evaluates one logic gate for deductive fault simulation. A fault list is a bit vector with one bit per fault: bit i set means that fault i makes the line carry the complement of its fault-free value. The unit accepts the fault-free values and fault lists of every input of an AND, OR, NAND or NOR gate, together with the fault indices of the gate output's own stuck-at-0 and stuck-at-1 faults. It returns the fault-free output value and the output fault list.

The output list is built in three steps. First, the input lists are combined with set operations, chosen by which inputs hold the gate's controlling value. Next, the output's own stuck-at fault opposite to its fault-free value is inserted. Finally, the stuck-at fault that matches the fault-free value is removed, because it cannot be observed. The result is registered. A flag reports whether the new list differs from the list the unit held before.

A sequencer walking a levelised netlist issues one evaluation per gate. It uses the changed flag to decide whether the gate's fanout must be scheduled again.

Top module: `dfsim_gate_eval`

## Requirements
- R1: `gate_kind` encodes 0 = AND, 1 = OR, 2 = NAND, 3 = NOR. The controlling value is 0 for AND/NAND and 1 for OR/NOR. The non-inverted result is the controlling value if any input holds it, and its complement otherwise. NAND and NOR complement that result on `out_val`.
- R2: If no input holds the controlling value, the propagated list is the union (bitwise OR) of all input lists.
- R3: If at least one input holds the controlling value, the propagated list is the intersection of the lists on the controlling inputs, minus the union of the lists on the remaining inputs. For example, a 2-input AND with a=0, A={1,3,4,6}, b=1, B={3,6} propagates {1,4}.
- R4: The output's own stuck-at fault opposite to `out_val` is set in `out_list`. If `out_val` is 1, bit `sa0_idx` is set; if `out_val` is 0, bit `sa1_idx` is set.
- R5: The output's own stuck-at fault whose stuck value equals `out_val` is cleared in `out_list`, even when an input list propagated it.
- R6: The list set operations for NAND and NOR are the same as for AND and OR. Local fault insertion and removal are referenced to the complemented `out_val`.
- R7: Input list k occupies bits [k*NUM_FAULTS +: NUM_FAULTS] of `in_list`, and bit i of any list stands for fault i. Results appear on the outputs in the cycle after `eval_valid` is high, and `out_valid` is high in exactly those cycles.
- R8: `out_changed` is high with a result exactly when the new `out_list` differs from the list held before. The first result after reset is compared against an empty list.
- R9: While `eval_valid` is low, `out_val` and `out_list` hold their values and `out_changed` is low, whatever the other inputs do.
- R10: After reset, `out_val`, `out_list`, `out_valid` and `out_changed` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eval_valid | input | 1 | Evaluate the presented gate this cycle |
| gate_kind | input | 2 | 0 AND, 1 OR, 2 NAND, 3 NOR |
| in_val | input | NUM_IN | Fault-free input values |
| in_list | input | NUM_IN*NUM_FAULTS | Packed input fault lists |
| sa0_idx | input | $clog2(NUM_FAULTS) | Index of output stuck-at-0 fault |
| sa1_idx | input | $clog2(NUM_FAULTS) | Index of output stuck-at-1 fault |
| out_val | output | 1 | Registered fault-free output value |
| out_list | output | NUM_FAULTS | Registered output fault list |
| out_valid | output | 1 | Result valid |
| out_changed | output | 1 | New list differs from previous list |

## Verification
Directed cases cover gates with no controlling input, with exactly one controlling input and with several controlling inputs. Each one separates the union path from the intersection-minus-union path. The 2-input AND example checks set difference on known indices. A case in which an input list already carries the output's same-valued stuck fault checks that removal happens after propagation. Random gate kinds, values and lists check all four kinds against a bench model. Repeated identical evaluations and idle cycles with changing inputs check the changed flag and the holding of results.

// File: rtl/dfsim_pkg.sv
package dfsim_pkg;
   typedef enum logic [1:0] {
      GK_AND  = 2'd0,
      GK_OR   = 2'd1,
      GK_NAND = 2'd2,
      GK_NOR  = 2'd3
   } gate_kind_e;

   // value that forces the gate output regardless of other inputs
   function automatic logic ctrl_value(gate_kind_e k);
      return (k == GK_OR) || (k == GK_NOR);
   endfunction

   function automatic logic is_inverting(gate_kind_e k);
      return (k == GK_NAND) || (k == GK_NOR);
   endfunction
endpackage

// File: rtl/dfsim_ctrl_classify.sv
module dfsim_ctrl_classify #(
   parameter int NUM_IN = 4
) (
   input  logic [1:0]        gate_kind,
   input  logic [NUM_IN-1:0] in_val,
   output logic [NUM_IN-1:0] ctrl_mask,
   output logic              any_ctrl,
   output logic              good_out
);
   import dfsim_pkg::*;

   gate_kind_e kind;
   logic       cval;
   logic       base_out;

   assign kind = gate_kind_e'(gate_kind);
   assign cval = ctrl_value(kind);

   for (genvar k = 0; k < NUM_IN; k++) begin : g_mask
      assign ctrl_mask[k] = (in_val[k] == cval);
   end

   assign any_ctrl = |ctrl_mask;
   assign base_out = any_ctrl ? cval : ~cval;
   assign good_out = base_out ^ is_inverting(kind);
endmodule

// File: rtl/dfsim_list_combine.sv
module dfsim_list_combine #(
   parameter int NUM_IN     = 4,
   parameter int NUM_FAULTS = 32
) (
   input  logic [NUM_IN*NUM_FAULTS-1:0] in_list,
   input  logic [NUM_IN-1:0]            ctrl_mask,
   input  logic                         any_ctrl,
   output logic [NUM_FAULTS-1:0]        prop_list
);
   typedef logic [NUM_FAULTS-1:0] flist_t;

   flist_t isect_acc [NUM_IN+1];
   flist_t other_acc [NUM_IN+1];
   flist_t union_acc [NUM_IN+1];

   assign isect_acc[0] = '1;
   assign other_acc[0] = '0;
   assign union_acc[0] = '0;

   for (genvar k = 0; k < NUM_IN; k++) begin : g_acc
      flist_t lst;
      assign lst            = in_list[k*NUM_FAULTS +: NUM_FAULTS];
      assign isect_acc[k+1] = isect_acc[k] & (ctrl_mask[k] ? lst : '1);
      assign other_acc[k+1] = other_acc[k] | (ctrl_mask[k] ? '0 : lst);
      assign union_acc[k+1] = union_acc[k] | lst;
   end

   assign prop_list = any_ctrl ? (isect_acc[NUM_IN] & ~other_acc[NUM_IN])
                               : union_acc[NUM_IN];
endmodule

// File: rtl/dfsim_local_fault.sv
module dfsim_local_fault #(
   parameter int NUM_FAULTS = 32,
   parameter int IDX_W      = 5
) (
   input  logic [NUM_FAULTS-1:0] prop_list,
   input  logic                  good_out,
   input  logic [IDX_W-1:0]      sa0_idx,
   input  logic [IDX_W-1:0]      sa1_idx,
   output logic [NUM_FAULTS-1:0] final_list
);
   logic [NUM_FAULTS-1:0] sa0_hot, sa1_hot, same_hot, opp_hot;

   for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_dec
      assign sa0_hot[i] = (sa0_idx == IDX_W'(i));
      assign sa1_hot[i] = (sa1_idx == IDX_W'(i));
   end

   // output at 1: stuck-at-1 is invisible, stuck-at-0 flips it
   assign same_hot   = good_out ? sa1_hot : sa0_hot;
   assign opp_hot    = good_out ? sa0_hot : sa1_hot;
   assign final_list = (prop_list & ~same_hot) | opp_hot;
endmodule

// File: rtl/dfsim_gate_eval.sv
module dfsim_gate_eval #(
   parameter int NUM_IN     = 4,
   parameter int NUM_FAULTS = 32,
   localparam int IDX_W     = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         eval_valid,
   input  logic [1:0]                   gate_kind,
   input  logic [NUM_IN-1:0]            in_val,
   input  logic [NUM_IN*NUM_FAULTS-1:0] in_list,
   input  logic [IDX_W-1:0]             sa0_idx,
   input  logic [IDX_W-1:0]             sa1_idx,
   output logic                         out_val,
   output logic [NUM_FAULTS-1:0]        out_list,
   output logic                         out_valid,
   output logic                         out_changed
);
   if (NUM_IN < 1) begin : g_bad_in
      $error("NUM_IN must be at least 1");
   end
   if (NUM_FAULTS < 2) begin : g_bad_nf
      $error("NUM_FAULTS must be at least 2");
   end

   logic [NUM_IN-1:0]     ctrl_mask;
   logic                  any_ctrl;
   logic                  good_out;
   logic [NUM_FAULTS-1:0] prop_list;
   logic [NUM_FAULTS-1:0] final_list;

   dfsim_ctrl_classify #(.NUM_IN(NUM_IN)) u_cls (
      .gate_kind (gate_kind),
      .in_val    (in_val),
      .ctrl_mask (ctrl_mask),
      .any_ctrl  (any_ctrl),
      .good_out  (good_out)
   );

   dfsim_list_combine #(.NUM_IN(NUM_IN), .NUM_FAULTS(NUM_FAULTS)) u_comb (
      .in_list   (in_list),
      .ctrl_mask (ctrl_mask),
      .any_ctrl  (any_ctrl),
      .prop_list (prop_list)
   );

   dfsim_local_fault #(.NUM_FAULTS(NUM_FAULTS), .IDX_W(IDX_W)) u_loc (
      .prop_list  (prop_list),
      .good_out   (good_out),
      .sa0_idx    (sa0_idx),
      .sa1_idx    (sa1_idx),
      .final_list (final_list)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_val     <= 1'b0;
         out_list    <= '0;
         out_valid   <= 1'b0;
         out_changed <= 1'b0;
      end else begin
         out_valid <= eval_valid;
         if (eval_valid) begin
            out_val     <= good_out;
            out_list    <= final_list;
            out_changed <= (final_list != out_list);
         end else begin
            out_changed <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dfsim_gate_eval_chk.sv
module dfsim_gate_eval_chk #(
   parameter int NUM_IN     = 4,
   parameter int NUM_FAULTS = 32,
   localparam int IDX_W     = (NUM_FAULTS > 1) ? $clog2(NUM_FAULTS) : 1
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         eval_valid,
   input logic [1:0]                   gate_kind,
   input logic [NUM_IN-1:0]            in_val,
   input logic [NUM_IN*NUM_FAULTS-1:0] in_list,
   input logic [IDX_W-1:0]             sa0_idx,
   input logic [IDX_W-1:0]             sa1_idx,
   input logic                         out_val,
   input logic [NUM_FAULTS-1:0]        out_list,
   input logic                         out_valid,
   input logic                         out_changed
);
   a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      eval_valid |=> out_valid);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_valid |=> ($stable(out_list) && $stable(out_val) && !out_changed && !out_valid));

   a_r8_changed_flag: assert property (@(posedge clk) disable iff (!rst_n)
      eval_valid |=> (out_changed == (out_list != $past(out_list))));

   a_r4_r5_local_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_valid && (sa0_idx != sa1_idx)) |=>
         ((out_list[$past(sa0_idx)] == out_val) && (out_list[$past(sa1_idx)] == !out_val)));

   a_r1_and_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_valid && (gate_kind == 2'd0) && (&in_val)) |=> out_val);

   a_r1_nor_any_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_valid && (gate_kind == 2'd3) && (|in_val)) |=> !out_val);
endmodule

bind dfsim_gate_eval dfsim_gate_eval_chk #(.NUM_IN(NUM_IN), .NUM_FAULTS(NUM_FAULTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .gate_kind(gate_kind),
   .in_val(in_val), .in_list(in_list), .sa0_idx(sa0_idx), .sa1_idx(sa1_idx),
   .out_val(out_val), .out_list(out_list), .out_valid(out_valid),
   .out_changed(out_changed)
);

// File: tb/dfsim_gate_eval_test.sv
module dfsim_gate_eval_test;
   localparam int CLK_P = 10;
   localparam int NI    = 4;
   localparam int NF    = 32;
   localparam int IW    = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           eval_valid = 1'b0;
   logic [1:0]     gate_kind = '0;
   logic [NI-1:0]  in_val = '0;
   logic [NI*NF-1:0] in_list = '0;
   logic [IW-1:0]  sa0_idx = '0;
   logic [IW-1:0]  sa1_idx = '0;
   logic           out_val;
   logic [NF-1:0]  out_list;
   logic           out_valid;
   logic           out_changed;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [NF-1:0] prev_list = '0;

   always #(CLK_P/2) clk = ~clk;

   dfsim_gate_eval #(.NUM_IN(NI), .NUM_FAULTS(NF)) uut (
      .clk(clk), .rst_n(rst_n), .eval_valid(eval_valid), .gate_kind(gate_kind),
      .in_val(in_val), .in_list(in_list), .sa0_idx(sa0_idx), .sa1_idx(sa1_idx),
      .out_val(out_val), .out_list(out_list), .out_valid(out_valid),
      .out_changed(out_changed)
   );

   task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", tag, got, exp);
      end
   endtask

   // expected value and list from the requirements (R1..R6)
   function automatic logic exp_val(logic [1:0] k, logic [NI-1:0] v);
      logic c = (k == 2'd1) || (k == 2'd3);
      logic any = 1'b0;
      for (int i = 0; i < NI; i++) if (v[i] == c) any = 1'b1;
      return (any ? c : ~c) ^ k[1];
   endfunction

   function automatic logic [NF-1:0] exp_list(logic [1:0] k, logic [NI-1:0] v,
                                              logic [NI*NF-1:0] l, logic [IW-1:0] s0,
                                              logic [IW-1:0] s1);
      logic c = (k == 2'd1) || (k == 2'd3);
      logic any = 1'b0;
      logic [NF-1:0] isect = '1, oth = '0, uni = '0, r;
      logic o;
      for (int i = 0; i < NI; i++) begin
         uni = uni | l[i*NF +: NF];
         if (v[i] == c) begin any = 1'b1; isect = isect & l[i*NF +: NF]; end
         else oth = oth | l[i*NF +: NF];
      end
      r = any ? (isect & ~oth) : uni;
      o = exp_val(k, v);
      if (o) begin r[s1] = 1'b0; r[s0] = 1'b1; end
      else   begin r[s0] = 1'b0; r[s1] = 1'b1; end
      return r;
   endfunction

   task automatic run_eval(string tag, logic [1:0] k, logic [NI-1:0] v,
                           logic [NI*NF-1:0] l, logic [IW-1:0] s0, logic [IW-1:0] s1);
      logic [NF-1:0] el;
      gate_kind = k; in_val = v; in_list = l; sa0_idx = s0; sa1_idx = s1;
      eval_valid = 1'b1;
      el = exp_list(k, v, l, s0, s1);
      @(negedge clk);
      check({tag, " R1 val"}, 64'(out_val), 64'(exp_val(k, v)));
      check({tag, " list"}, 64'(out_list), 64'(el));
      check({tag, " R7 valid"}, 64'(out_valid), 64'd1);
      check({tag, " R8 changed"}, 64'(out_changed), 64'(el != prev_list));
      prev_list = el;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [NI*NF-1:0] l;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check("R10 val", 64'(out_val), 64'd0);
      check("R10 list", 64'(out_list), 64'd0);
      check("R10 valid", 64'(out_valid), 64'd0);
      check("R10 changed", 64'(out_changed), 64'd0);

      // R3 example: AND a=0 A={1,3,4,6}, b=1 B={3,6}, other inputs 1 and empty
      l = '0;
      l[0*NF +: NF] = 32'h5A;
      l[1*NF +: NF] = 32'h48;
      run_eval("R3 and_example", 2'd0, 4'b1110, l, 5'd21, 5'd20);
      check("R3 example list", 64'(out_list), 64'(32'h0010_0012));

      // R5: input list already holds same-valued stuck-at-0 (out=0)
      l[0*NF +: NF] = 32'h0020_005A;
      run_eval("R5 same_removed", 2'd0, 4'b1110, l, 5'd21, 5'd20);
      check("R5 bit21 clear", 64'(out_list[21]), 64'd0);

      // R8: identical evaluation -> not changed
      run_eval("R8 repeat", 2'd0, 4'b1110, l, 5'd21, 5'd20);
      check("R8 repeat flag", 64'(out_changed), 64'd0);

      // R2: OR with no controlling input -> union
      l = {32'h1, 32'h10, 32'h100, 32'h1000};
      run_eval("R2 or_union", 2'd1, 4'b0000, l, 5'd30, 5'd31);
      check("R2 union list", 64'(out_list), 64'(32'h8000_1111));

      // R6: NOR same data, inverted output
      run_eval("R6 nor_union", 2'd3, 4'b0000, l, 5'd30, 5'd31);
      check("R6 nor list", 64'(out_list), 64'(32'h4000_1111));

      // R3: NAND with two controlling inputs
      l = {32'h0F0F, 32'hFF00, 32'h00FF, 32'h0FF0};
      run_eval("R3 nand_two", 2'd2, 4'b0101, l, 5'd28, 5'd29);

      // R9: idle with changing inputs
      eval_valid = 1'b0;
      prev_list = out_list;
      gate_kind = 2'd1; in_val = 4'b1111; in_list = '1;
      @(negedge clk);
      check("R9 list hold", 64'(out_list), 64'(prev_list));
      check("R9 changed low", 64'(out_changed), 64'd0);
      check("R9 valid low", 64'(out_valid), 64'd0);
      check("R9 val hold", 64'(out_val), 64'(exp_val(2'd2, 4'b0101)));

      // random mix of all kinds
      for (int n = 0; n < 400; n++) begin
         logic [IW-1:0] s0, s1;
         s0 = IW'($urandom);
         s1 = IW'($urandom);
         if (s1 == s0) s1 = s0 + 1'b1;
         l = {$urandom, $urandom, $urandom, $urandom};
         run_eval("R1 R2 R3 R4 R6 random", 2'($urandom), NI'($urandom), l, s0, s1);
      end
      eval_valid = 1'b0;
      @(negedge clk);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule